// File: doc/BRIEF.md
# Eight-Input Prioritizing Interrupt Controller

This block gathers eight interrupt request lines and picks the most urgent one that is neither masked nor shadowed by a request already being serviced. It offers that request to the processor as a vector number. A host talks to it through one byte-wide write path and one byte-wide read path, and a port-select pin chooses between a command port and a data port. Before the controller raises any request, software must program it with a short run of setup words. Once setup is done, writes to the data port load the mask. Writes to the command port either choose which status register the command port reads back, or retire the current in-service request.

The outgoing request is a valid/ready pair. `int_valid` with `int_vector` is the offer and `int_ready` is the acknowledge. The offer is an interrupt line, not a queued stream: the vector may change while `int_valid` stays high, when a more urgent input arrives, and `int_valid` may drop without a handshake when the mask changes. An acknowledge counts only on a clock edge where `int_valid` is high. When it is low, `int_ready` has no effect. Two copies can be chained. The upstream copy names the input that carries the downstream copy's request. The downstream copy answers an acknowledge only when that name matches its own identity.

Top module: `intc8_core`

## Requirements
- R1: After reset the request register and the in-service register are 0x00, the mask is 0xFF, a command-port read returns the request register, and `int_valid` stays low until setup has completed, even when requests are recorded.
- R2: A command write with bit 4 set starts setup. It clears the request and in-service registers. Its bit 1 set means no chaining word follows, and its bit 0 set means a mode word follows. The next data writes are taken in order as vector base, chaining word (if expected) and mode word (if expected). None of them changes the mask.
- R3: After setup, a data write loads the mask and a data read returns it. A mask bit of 1 keeps that input from being offered.
- R4: A rising edge on `irq_in[k]` sets request bit k at the next clock edge. A line held high sets nothing more.
- R5: `int_valid` is high when an unmasked request bit exists whose index is lower than every in-service bit. The lowest such index wins, and `int_vector` = base + index (mod 256). It is 0x00 when nothing is offered.
- R6: An accepted acknowledge clears the winning request bit and sets the same in-service bit at that edge. `int_ready` with `int_valid` low changes nothing.
- R7: A command write with bit 4 = 0, bit 3 = 1 and bit 1 = 1 sets the command-port read source: bit 0 = 0 selects the request register (0x0A) and bit 0 = 1 selects the in-service register (0x0B).
- R8: A command write with bits 7:5 = 001, bit 4 = 0 and bit 3 = 0 (0x20) clears the lowest-index set in-service bit.
- R9: With `slave_mode` low, chaining-word bit k set marks input k as chained. While such an input is the winner, `cas_active` is high and `cas_code_out` = k. Otherwise both are 0.
- R10: With `slave_mode` high, bits 2:0 of the chaining word are the identity. An acknowledge is accepted only when `cas_code_in` equals it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | Strap: 1 makes this copy the downstream one |
| wr_en | input | 1 | Host write strobe |
| port_sel | input | 1 | 1 selects the command port, 0 the data port |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte for the selected port |
| irq_in | input | 8 | Request lines, synchronous, edge sensed |
| int_valid | output | 1 | Request offered to the processor |
| int_ready | input | 1 | Acknowledge from the processor |
| int_vector | output | 8 | Vector of the offered request |
| cas_active | output | 1 | Winner is a chained input (upstream role) |
| cas_code_out | output | 3 | Index of the chained winner |
| cas_code_in | input | 3 | Chain code seen by a downstream copy |

## Verification
The assertions assume that `irq_in` is already synchronous to `clk`. They also assume that a setup-start command never lands in the same cycle as an accepted acknowledge or a request edge, because the start takes priority and those events are lost. The bench changes every input only on the falling clock edge, holds each command for exactly one rising edge, and issues setup only while nothing is offered. Acknowledges are sent both with and without an offer pending, and on the downstream copy both with a matching chain code and with a wrong one.

// File: rtl/intc8_pkg.sv
package intc8_pkg;
  typedef enum logic [2:0] {
    IS_OFF  = 3'd0,
    IS_BASE = 3'd1,
    IS_CASC = 3'd2,
    IS_MODE = 3'd3,
    IS_RUN  = 3'd4
  } init_st_e;

  localparam logic [2:0] EOI_NONSPEC = 3'b001;
endpackage

// File: rtl/intc8_init_seq.sv
module intc8_init_seq
  import intc8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic want_mode,
  input  logic no_casc,
  input  logic data_wr,
  output logic cap_base,
  output logic cap_casc,
  output logic running
);
  init_st_e st, st_nx;
  logic     need_casc, need_mode;

  always_comb begin
    st_nx = st;
    if (data_wr) begin
      unique case (st)
        IS_BASE: st_nx = need_casc ? IS_CASC : (need_mode ? IS_MODE : IS_RUN);
        IS_CASC: st_nx = need_mode ? IS_MODE : IS_RUN;
        IS_MODE: st_nx = IS_RUN;
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IS_OFF;
      need_casc <= 1'b0;
      need_mode <= 1'b0;
    end else if (start) begin
      st        <= IS_BASE;
      need_casc <= !no_casc;
      need_mode <= want_mode;
    end else begin
      st <= st_nx;
    end
  end

  assign cap_base = data_wr && (st == IS_BASE);
  assign cap_casc = data_wr && (st == IS_CASC);
  assign running  = (st == IS_RUN);

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == IS_BASE));
  // R2
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start) |=> running);
endmodule

// File: rtl/intc8_lowfind.sv
module intc8_lowfind #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc8_core.sv
module intc8_core
  import intc8_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int DW     = 8,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_mode,
  input  logic             wr_en,
  input  logic             port_sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NUM_IN-1:0] irq_in,
  output logic             int_valid,
  input  logic             int_ready,
  output logic [DW-1:0]    int_vector,
  output logic             cas_active,
  output logic [IDX_W-1:0] cas_code_out,
  input  logic [IDX_W-1:0] cas_code_in
);
  logic [NUM_IN-1:0] irr, isr, mask, irq_prev, casw;
  logic [DW-1:0]     base;
  logic              rsel_isr;

  logic cmd_wr, data_wr, init_start, running, cap_base, cap_casc;
  logic ocw, eoi, rsel_wr, accept;
  logic win_any, top_any;
  logic [IDX_W-1:0] win_idx, top_idx;
  logic [NUM_IN-1:0] eligible, rise, win_oh, top_oh;

  assign cmd_wr     = wr_en && port_sel;
  assign data_wr    = wr_en && !port_sel;
  assign init_start = cmd_wr && wdata[4];
  assign ocw        = cmd_wr && !wdata[4] && running;
  assign eoi        = ocw && !wdata[3] && (wdata[7:5] == EOI_NONSPEC);
  assign rsel_wr    = ocw && wdata[3] && wdata[1];

  intc8_init_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (init_start),
    .want_mode(wdata[0]),
    .no_casc  (wdata[1]),
    .data_wr  (data_wr),
    .cap_base (cap_base),
    .cap_casc (cap_casc),
    .running  (running)
  );

  assign eligible = irr & ~mask;
  assign rise     = irq_in & ~irq_prev;

  intc8_lowfind #(.N(NUM_IN)) u_req_find (.vec(eligible), .any(win_any), .idx(win_idx));
  intc8_lowfind #(.N(NUM_IN)) u_svc_find (.vec(isr),      .any(top_any), .idx(top_idx));

  assign win_oh = NUM_IN'(1) << win_idx;
  assign top_oh = NUM_IN'(1) << top_idx;

  assign int_valid = running && win_any && (!top_any || (win_idx < top_idx));
  assign accept    = int_valid && int_ready &&
                     (!slave_mode || (cas_code_in == casw[IDX_W-1:0]));

  assign int_vector   = int_valid ? (base + DW'(win_idx)) : '0;
  assign cas_active   = int_valid && !slave_mode && casw[win_idx];
  assign cas_code_out = cas_active ? win_idx : '0;

  assign rdata = port_sel ? (rsel_isr ? isr : irr) : mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev <= '0;
      irr      <= '0;
      isr      <= '0;
      mask     <= '1;
      base     <= '0;
      casw     <= '0;
      rsel_isr <= 1'b0;
    end else begin
      irq_prev <= irq_in;
      if (init_start) begin
        irr <= '0;
        isr <= '0;
      end else begin
        irr <= (irr & ~(accept ? win_oh : '0)) | rise;
        isr <= (isr & ~((eoi && top_any) ? top_oh : '0)) | (accept ? win_oh : '0);
      end
      if (cap_base)             base     <= wdata;
      if (cap_casc)             casw     <= wdata;
      if (data_wr && running)   mask     <= wdata;
      if (rsel_wr)              rsel_isr <= wdata[0];
    end
  end

  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && running) |=> (mask == $past(wdata)));
  // R4
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_start && (rise != '0)) |=> ((irr & $past(rise)) == $past(rise)));
  // R5
  offer_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> ((irr & ~mask & ~isr) != '0));
  // R6
  ack_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !init_start) |=> ((isr & $past(win_oh)) != '0));
  // R8
  eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !accept && !init_start && (isr != '0)) |=>
      ($countones(isr) == $countones($past(isr)) - 1));
  // R9
  cas_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_valid |-> (!cas_active && (cas_code_out == '0)));
endmodule

// File: tb/intc8_core_bench.sv
`timescale 1ns/1ps
module intc8_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0;
  logic wr_en = 1'b0;
  logic port_sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq_in = 8'h00;
  logic int_valid, cas_active;
  logic int_ready = 1'b0;
  logic [7:0] int_vector;
  logic [2:0] cas_code_out;
  logic [2:0] cas_code_in = 3'd0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intc8_core u_intc8_core (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .wr_en(wr_en),
    .port_sel(port_sel), .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
    .int_valid(int_valid), .int_ready(int_ready), .int_vector(int_vector),
    .cas_active(cas_active), .cas_code_out(cas_code_out), .cas_code_in(cas_code_in)
  );

  // behavioural reference state
  logic [7:0] m_irr = 0, m_isr = 0, m_mask = 8'hFF, m_base = 0, m_casw = 0, m_prev = 0;
  int m_st = 0;
  bit m_n3 = 0, m_n4 = 0, m_rsel = 0;

  function automatic int lowbit(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit e_valid();
    int w = lowbit(m_irr & ~m_mask);
    return (m_st == 4) && (w < 8) && (w < lowbit(m_isr));
  endfunction

  function automatic logic [7:0] e_vec();
    return e_valid() ? m_base + 8'(lowbit(m_irr & ~m_mask)) : 8'h00;
  endfunction

  function automatic bit e_cas();
    return e_valid() && !slave_mode && m_casw[lowbit(m_irr & ~m_mask)];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_mask = 8'hFF; m_base = 0; m_casw = 0; m_prev = 0;
      m_st = 0; m_n3 = 0; m_n4 = 0; m_rsel = 0;
    end else begin
      logic [7:0] rise;
      int w;
      bit acc;
      rise = irq_in & ~m_prev;
      m_prev = irq_in;
      w = lowbit(m_irr & ~m_mask);
      acc = e_valid() && int_ready && (!slave_mode || cas_code_in == m_casw[2:0]);
      if (wr_en && port_sel && wdata[4]) begin
        m_irr = 0; m_isr = 0; m_st = 1; m_n3 = !wdata[1]; m_n4 = wdata[0];
      end else begin
        if (wr_en && port_sel && m_st == 4 && !wdata[4]) begin
          if (!wdata[3] && wdata[7:5] == 3'b001 && m_isr != 0) m_isr[lowbit(m_isr)] = 1'b0;
          if (wdata[3] && wdata[1]) m_rsel = wdata[0];
        end
        if (acc) begin m_isr[w] = 1'b1; m_irr[w] = 1'b0; end
        m_irr = m_irr | rise;
        if (wr_en && !port_sel) begin
          case (m_st)
            1: begin m_base = wdata; m_st = m_n3 ? 2 : (m_n4 ? 3 : 4); end
            2: begin m_casw = wdata; m_st = m_n4 ? 3 : 4; end
            3: m_st = 4;
            4: m_mask = wdata;
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // clock-by-clock comparison against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R5 int_valid", 8'(int_valid), 8'(e_valid()));
      chk("R5 int_vector", int_vector, e_vec());
      chk("R9 cas_active", 8'(cas_active), 8'(e_cas()));
      chk("R9 cas_code_out", 8'(cas_code_out), e_cas() ? 8'(lowbit(m_irr & ~m_mask)) : 8'h00);
      chk("R3/R7 rdata", rdata, port_sel ? (m_rsel ? m_isr : m_irr) : m_mask);
    end
  end

  task automatic idle();
    @(negedge clk);
    wr_en = 0; int_ready = 0;
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; port_sel = sel; wdata = d;
    idle();
  endtask

  task automatic ack(logic [2:0] code);
    @(negedge clk);
    int_ready = 1; cas_code_in = code;
    idle();
  endtask

  task automatic rd(bit sel, logic [7:0] exp, string tag);
    @(negedge clk);
    port_sel = sel;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic see(logic v, logic [7:0] vec, string tag);
    @(negedge clk);
    #1;
    chk(tag, 8'(int_valid), 8'(v));
    chk(tag, int_vector, vec);
  endtask

  task automatic irq(int k, bit lvl);
    @(negedge clk);
    irq_in[k] = lvl;
    idle();
  endtask

  task automatic do_reset(bit sm);
    @(negedge clk);
    rst_n = 0; slave_mode = sm; irq_in = 0; wr_en = 0; int_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
  end

  initial begin
    do_reset(0);
    rd(1, 8'h00, "R1 irr after reset");
    rd(0, 8'hFF, "R1 mask after reset");
    irq(3, 1);
    rd(1, 8'h08, "R4 edge recorded");
    see(0, 8'h00, "R1 no offer before setup");
    wr(1, 8'h11);
    rd(1, 8'h00, "R2 setup clears irr");
    wr(0, 8'h20); wr(0, 8'h04); wr(0, 8'h01);
    rd(0, 8'hFF, "R2 setup words leave mask");
    wr(0, 8'h00);
    rd(0, 8'h00, "R3 mask loaded");
    see(0, 8'h00, "R4 held level no retrigger");
    irq(5, 1);
    see(1, 8'h25, "R5 vector base+5");
    irq(1, 1);
    see(1, 8'h21, "R5 input 1 outranks 5");
    ack(3'd0);
    see(0, 8'h00, "R5 blocked by in-service");
    wr(1, 8'h0B);
    rd(1, 8'h02, "R6 R7 isr read");
    wr(1, 8'h0A);
    rd(1, 8'h20, "R7 irr read");
    wr(1, 8'h20);
    see(1, 8'h25, "R8 eoi reopens");
    wr(0, 8'h20);
    see(0, 8'h00, "R3 mask bit blocks");
    irq(2, 1);
    see(1, 8'h22, "R9 chained input");
    chk("R9 cas_active", 8'(cas_active), 8'h01);
    chk("R9 cas_code", 8'(cas_code_out), 8'h02);
    ack(3'd0);
    irq(0, 1);
    see(1, 8'h20, "R9 input 0 over chained");
    chk("R9 not chained", 8'(cas_active), 8'h00);
    ack(3'd0);
    wr(1, 8'h0B);
    rd(1, 8'h05, "R6 two in service");
    wr(1, 8'h20);
    rd(1, 8'h04, "R8 lowest cleared first");
    wr(1, 8'h20);
    rd(1, 8'h00, "R8 second eoi");
    ack(3'd0);
    rd(1, 8'h00, "R6 ack without offer ignored");
    wr(1, 8'h13); wr(0, 8'h40); wr(0, 8'h01); wr(0, 8'h00);
    rd(0, 8'h00, "R2 single skips chaining word");
    @(negedge clk); irq_in = 0;
    irq(7, 1);
    see(1, 8'h47, "R2 R5 new base");

    do_reset(1);
    wr(1, 8'h11); wr(0, 8'h28); wr(0, 8'h02); wr(0, 8'h01); wr(0, 8'h00);
    irq(4, 1);
    see(1, 8'h2C, "R10 slave offer");
    chk("R9 slave never chains", 8'(cas_active), 8'h00);
    ack(3'd3);
    wr(1, 8'h0B);
    rd(1, 8'h00, "R10 wrong code ignored");
    ack(3'd2);
    rd(1, 8'h10, "R10 matching code accepted");
    repeat (3) idle();
    done = 1;
    summary();
  end
endmodule